// File: doc/BRIEF.md
# Indexed Colour Palette with Direct-Colour Bypass

This block turns pixel values into 8-bit red, green and blue components. In indexed mode an 8-bit pixel code picks one of 256 stored 24-bit colours. In the three direct modes the pixel word itself carries the colour and the table is not consulted. Narrow 5-bit and 6-bit fields are widened to 8 bits by repeating their most significant bits in the low bits. Every pixel result leaves through a register, one clock after the pixel is presented.

The host reaches the table through three byte-wide locations: a read pointer, a write pointer and a shared data location. A colour is moved as three consecutive data accesses: red first, then green, then blue. A single phase counter tracks which component comes next. When the blue access completes, the pointer in use moves to the next entry and wraps from the last entry to entry 0. Loading the read pointer also fetches the addressed entry into a holding register. Data reads are then served from that register.

Top module: `pal_lut`

## Requirements
- R1: While reset is asserted and right after it, both pointers read back as 0 and the three pixel outputs are 0.
- R2: Three data writes, in the order red, green, blue, store one 24-bit colour at the write pointer. The entry changes only when the blue byte is written, and the write pointer then advances by one.
- R3: The write pointer advances from 255 to 0 after a blue write.
- R4: Loading the read pointer fetches that entry. Three data reads then return red, green and blue in that order, after which the read pointer advances by one and wraps from 255 to 0.
- R5: Writing either pointer location returns the phase counter to red. A partly written or partly read colour is abandoned and the table is left untouched.
- R6: With pixel mode 0 (indexed), the outputs show the entry chosen by pixel bits [7:0] on the clock edge after the pixel is presented, and not earlier.
- R7: A colour completed by a blue write at edge E is seen by the pixel lookup from edge E+1. A lookup taken at edge E still returns the old colour.
- R8: Pixel mode 1 (15 bpp) takes red from bits [14:10], green from [9:5] and blue from [4:0]. Bit 15 and above are ignored. Each 5-bit field f becomes {f, f[4:2]}.
- R9: Pixel mode 2 (16 bpp) takes red from bits [15:11], green from [10:5] and blue from [4:0]. The 5-bit fields become {f, f[4:2]} and the 6-bit field becomes {f, f[5:4]}.
- R10: Pixel mode 3 (24 bpp) passes bits [23:16], [15:8] and [7:0] straight to red, green and blue.
- R11: Host address 0 is unused. An access to it changes no pointer, no phase and no table entry, and reads return 0. Address 1 is the read pointer, 2 the write pointer and 3 the data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host access strobe, one access per cycle |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | 0 unused, 1 read pointer, 2 write pointer, 3 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the access cycle |
| pix_mode | input | 2 | 0 indexed, 1 15 bpp, 2 16 bpp, 3 24 bpp |
| pix_data | input | 24 | Pixel word |
| pix_red | output | 8 | Registered red component |
| pix_green | output | 8 | Registered green component |
| pix_blue | output | 8 | Registered blue component |

## Verification
The assertions take for granted that `pix_mode`, `pix_data`, `host_addr` and the host strobes hold known values and change only between clock edges. The direct-mode properties compare each output with the pixel word seen one edge earlier. The pointer and phase properties assume that at most one host access happens per cycle. The stimulus drives every input on the falling edge and holds it through the next rising edge. It also writes every table entry it looks up before using it, because entries are undefined after reset.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;

    typedef logic [7:0] comp_t;

    typedef struct packed {
        comp_t r;
        comp_t g;
        comp_t b;
    } rgb_t;

    typedef enum logic [1:0] {
        HA_NONE   = 2'd0,
        HA_RD_PTR = 2'd1,
        HA_WR_PTR = 2'd2,
        HA_DATA   = 2'd3
    } host_addr_e;

    typedef enum logic [1:0] {
        PM_INDEX = 2'd0,
        PM_555   = 2'd1,
        PM_565   = 2'd2,
        PM_888   = 2'd3
    } pix_mode_e;

    typedef enum logic [1:0] {
        PH_RED   = 2'd0,
        PH_GREEN = 2'd1,
        PH_BLUE  = 2'd2
    } phase_e;

    function automatic comp_t widen5(input logic [4:0] f);
        return {f, f[4:2]};
    endfunction

    function automatic comp_t widen6(input logic [5:0] f);
        return {f, f[5:4]};
    endfunction

    function automatic phase_e phase_next(input phase_e p);
        case (p)
            PH_RED:   return PH_GREEN;
            PH_GREEN: return PH_BLUE;
            default:  return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/pal_lut_store.sv
module pal_lut_store
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  rgb_t             wdata,
    input  logic [IDX_W-1:0] host_raddr,
    output rgb_t             host_rdata,
    input  logic [IDX_W-1:0] pix_raddr,
    output rgb_t             pix_rdata
);
    localparam int DEPTH = 1 << IDX_W;

    rgb_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign host_rdata = mem_q[host_raddr];
    assign pix_rdata  = mem_q[pix_raddr];

endmodule

// File: rtl/pal_lut_host.sv
module pal_lut_host
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_addr,
    input  logic [7:0]       acc_wdata,
    output logic [7:0]       acc_rdata,
    output logic [IDX_W-1:0] fetch_addr,
    input  rgb_t             fetch_data,
    output logic             mem_we,
    output logic [IDX_W-1:0] mem_waddr,
    output rgb_t             mem_wdata,
    output logic [1:0]       phase_o,
    output logic [IDX_W-1:0] wr_ptr_o
);
    localparam logic [IDX_W-1:0] PTR_STEP = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] rd_ptr;
        logic [IDX_W-1:0] wr_ptr;
        phase_e           phase;
        comp_t            hold_r;
        comp_t            hold_g;
        rgb_t             rd_buf;
    } host_state_t;

    host_state_t s_d, s_q;
    host_addr_e  addr;

    assign addr = host_addr_e'(acc_addr);

    always_comb begin
        s_d        = s_q;
        mem_we     = 1'b0;
        mem_waddr  = s_q.wr_ptr;
        mem_wdata  = '{r: s_q.hold_r, g: s_q.hold_g, b: acc_wdata};
        fetch_addr = s_q.rd_ptr;
        if (acc_valid) begin
            case (addr)
                HA_RD_PTR: begin
                    if (acc_write) begin
                        s_d.rd_ptr = acc_wdata[IDX_W-1:0];
                        s_d.phase  = PH_RED;
                        fetch_addr = acc_wdata[IDX_W-1:0];
                        s_d.rd_buf = fetch_data;
                    end
                end
                HA_WR_PTR: begin
                    if (acc_write) begin
                        s_d.wr_ptr = acc_wdata[IDX_W-1:0];
                        s_d.phase  = PH_RED;
                    end
                end
                HA_DATA: begin
                    s_d.phase = phase_next(s_q.phase);
                    if (acc_write) begin
                        case (s_q.phase)
                            PH_RED:   s_d.hold_r = acc_wdata;
                            PH_GREEN: s_d.hold_g = acc_wdata;
                            default: begin
                                mem_we     = 1'b1;
                                s_d.wr_ptr = s_q.wr_ptr + PTR_STEP;
                            end
                        endcase
                    end else if (s_q.phase == PH_BLUE) begin
                        s_d.rd_ptr = s_q.rd_ptr + PTR_STEP;
                        fetch_addr = s_q.rd_ptr + PTR_STEP;
                        s_d.rd_buf = fetch_data;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            HA_RD_PTR: acc_rdata = 8'(s_q.rd_ptr);
            HA_WR_PTR: acc_rdata = 8'(s_q.wr_ptr);
            HA_DATA: begin
                case (s_q.phase)
                    PH_RED:   acc_rdata = s_q.rd_buf.r;
                    PH_GREEN: acc_rdata = s_q.rd_buf.g;
                    default:  acc_rdata = s_q.rd_buf.b;
                endcase
            end
            default: acc_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{rd_ptr: '0, wr_ptr: '0, phase: PH_RED,
                     hold_r: '0, hold_g: '0, rd_buf: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = s_q.phase;
    assign wr_ptr_o = s_q.wr_ptr;

endmodule

// File: rtl/pal_lut_pixel.sv
module pal_lut_pixel
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [23:0]      pix,
    output logic [IDX_W-1:0] lut_addr,
    input  rgb_t             lut_data,
    output rgb_t             rgb_o
);
    rgb_t rgb_d, rgb_q;

    assign lut_addr = pix[IDX_W-1:0];

    always_comb begin
        case (pix_mode_e'(mode))
            PM_INDEX: rgb_d = lut_data;
            PM_555:   rgb_d = '{r: widen5(pix[14:10]), g: widen5(pix[9:5]),
                                b: widen5(pix[4:0])};
            PM_565:   rgb_d = '{r: widen5(pix[15:11]), g: widen6(pix[10:5]),
                                b: widen5(pix[4:0])};
            default:  rgb_d = '{r: pix[23:16], g: pix[15:8], b: pix[7:0]};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_q <= '0;
        end else begin
            rgb_q <= rgb_d;
        end
    end

    assign rgb_o = rgb_q;

endmodule

// File: rtl/pal_lut.sv
module pal_lut
    import pal_lut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [1:0]  pix_mode,
    input  logic [23:0] pix_data,
    output logic [7:0]  pix_red,
    output logic [7:0]  pix_green,
    output logic [7:0]  pix_blue
);
    logic             mem_we;
    logic [IDX_W-1:0] mem_waddr;
    rgb_t             mem_wdata;
    logic [IDX_W-1:0] fetch_addr;
    rgb_t             fetch_data;
    logic [IDX_W-1:0] lut_addr;
    rgb_t             lut_data;
    rgb_t             rgb;
    logic [1:0]       phase_w;
    logic [IDX_W-1:0] wr_ptr_w;

    pal_lut_host #(.IDX_W(IDX_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (host_valid),
        .acc_write  (host_write),
        .acc_addr   (host_addr),
        .acc_wdata  (host_wdata),
        .acc_rdata  (host_rdata),
        .fetch_addr (fetch_addr),
        .fetch_data (fetch_data),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .phase_o    (phase_w),
        .wr_ptr_o   (wr_ptr_w)
    );

    pal_lut_store #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .we         (mem_we),
        .waddr      (mem_waddr),
        .wdata      (mem_wdata),
        .host_raddr (fetch_addr),
        .host_rdata (fetch_data),
        .pix_raddr  (lut_addr),
        .pix_rdata  (lut_data)
    );

    pal_lut_pixel #(.IDX_W(IDX_W)) u_pixel (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (pix_mode),
        .pix      (pix_data),
        .lut_addr (lut_addr),
        .lut_data (lut_data),
        .rgb_o    (rgb)
    );

    assign pix_red   = rgb.r;
    assign pix_green = rgb.g;
    assign pix_blue  = rgb.b;

endmodule

// File: rtl/pal_lut_checker.sv
module pal_lut_checker #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_valid,
    input logic             host_write,
    input logic [1:0]       host_addr,
    input logic [1:0]       pix_mode,
    input logic [23:0]      pix_data,
    input logic [7:0]       pix_red,
    input logic [7:0]       pix_green,
    input logic [7:0]       pix_blue,
    input logic             mem_we,
    input logic [1:0]       phase,
    input logic [IDX_W-1:0] wr_ptr
);
    // R2: the phase counter never reaches the unused code
    a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
        phase != 2'd3);

    // R2, R3: a committed colour moves the write pointer on by one, modulo depth
    a_r3_wr_advance: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> wr_ptr == IDX_W'($past(wr_ptr) + 1'b1));

    // R5: loading either pointer restarts at red
    a_r5_ptr_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && (host_addr == 2'd1 || host_addr == 2'd2))
        |=> phase == 2'd0);

    // R11: the unused address leaves phase and write pointer alone
    a_r11_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_addr == 2'd0) |=> ($stable(phase) && $stable(wr_ptr)));

    // R8: 15 bpp red field widened with its top bits repeated
    a_r8_555_red: assert property (@(posedge clk) disable iff (!rst_n)
        pix_mode == 2'd1 |=>
        (pix_red[7:3] == $past(pix_data[14:10]) && pix_red[2:0] == pix_red[7:5]));

    // R9: 16 bpp green field widened from six bits
    a_r9_565_green: assert property (@(posedge clk) disable iff (!rst_n)
        pix_mode == 2'd2 |=>
        (pix_green[7:2] == $past(pix_data[10:5]) && pix_green[1:0] == pix_green[7:6]));

    // R10: 24 bpp passes through after one clock
    a_r10_888_pass: assert property (@(posedge clk) disable iff (!rst_n)
        pix_mode == 2'd3 |=> {pix_red, pix_green, pix_blue} == $past(pix_data));

endmodule

bind pal_lut pal_lut_checker #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_valid (host_valid),
    .host_write (host_write),
    .host_addr  (host_addr),
    .pix_mode   (pix_mode),
    .pix_data   (pix_data),
    .pix_red    (pix_red),
    .pix_green  (pix_green),
    .pix_blue   (pix_blue),
    .mem_we     (mem_we),
    .phase      (phase_w),
    .wr_ptr     (wr_ptr_w)
);

// File: tb/tb_pal_lut.sv
`timescale 1ns/1ps
module tb_pal_lut;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic        host_write = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [1:0]  pix_mode = 2'd0;
    logic [23:0] pix_data = 24'h0;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    pal_lut dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_mode(pix_mode), .pix_data(pix_data),
        .pix_red(pix_red), .pix_green(pix_green), .pix_blue(pix_blue)
    );

    localparam logic [1:0] A_NONE = 2'd0, A_RD = 2'd1, A_WR = 2'd2, A_DAT = 2'd3;

    // {mode, pixel word, expected rgb}
    localparam logic [49:0] VEC [8] = '{
        {2'd1, 24'h007FFF, 24'hFFFFFF},  // R8
        {2'd1, 24'h007C00, 24'hFF0000},  // R8
        {2'd1, 24'h000210, 24'h008484},  // R8
        {2'd1, 24'h008000, 24'h000000},  // R8 bit 15 ignored
        {2'd2, 24'h00F800, 24'hFF0000},  // R9
        {2'd2, 24'h0007E0, 24'h00FF00},  // R9
        {2'd2, 24'h008410, 24'h848284},  // R9
        {2'd3, 24'h123456, 24'h123456}   // R10
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [1:0] a, input logic w, input logic [7:0] d,
                       output logic [7:0] q);
        @(negedge clk);
        host_valid = 1'b1; host_write = w; host_addr = a; host_wdata = d;
        #1 q = host_rdata;
        @(posedge clk);
        #1 host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic put_entry(input logic [7:0] idx, input logic [23:0] c);
        logic [7:0] q;
        acc(A_WR, 1'b1, idx, q);
        acc(A_DAT, 1'b1, c[23:16], q);
        acc(A_DAT, 1'b1, c[15:8], q);
        acc(A_DAT, 1'b1, c[7:0], q);
    endtask

    task automatic get_next(output logic [23:0] c);
        logic [7:0] q;
        acc(A_DAT, 1'b0, 8'h00, q); c[23:16] = q;
        acc(A_DAT, 1'b0, 8'h00, q); c[15:8]  = q;
        acc(A_DAT, 1'b0, 8'h00, q); c[7:0]   = q;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(150_000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  q;
        logic [23:0] c;

        // R1: state during and after reset
        repeat (3) @(negedge clk);
        host_addr = A_RD; #1;
        check("R1 rd ptr in reset", host_rdata, 8'h00);
        check("R1 rgb in reset", {pix_red, pix_green, pix_blue}, 24'h0);
        @(negedge clk); rst_n = 1'b1;
        acc(A_WR, 1'b0, 8'h00, q);
        check("R1 wr ptr after reset", q, 8'h00);

        // R8, R9, R10: direct modes from the vector table
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pix_mode = VEC[i][49:48];
            pix_data = VEC[i][47:24];
            @(negedge clk);
            check(pix_mode == 2'd1 ? "R8 555" : pix_mode == 2'd2 ? "R9 565" : "R10 888",
                  {pix_red, pix_green, pix_blue}, VEC[i][23:0]);
        end

        // R2, R4: write one colour, read it back
        put_entry(8'd5, 24'h112233);
        acc(A_WR, 1'b0, 8'h00, q);
        check("R2 wr ptr advance", q, 8'd6);
        acc(A_RD, 1'b1, 8'd5, q);
        get_next(c);
        check("R4 readback entry 5", c, 24'h112233);
        acc(A_RD, 1'b0, 8'h00, q);
        check("R4 rd ptr advance", q, 8'd6);

        // R3, R4: wrap at the end of the table
        put_entry(8'd255, 24'hAABBCC);
        acc(A_DAT, 1'b1, 8'h01, q);
        acc(A_DAT, 1'b1, 8'h02, q);
        acc(A_DAT, 1'b1, 8'h03, q);
        acc(A_WR, 1'b0, 8'h00, q);
        check("R3 wr ptr wrap", q, 8'd1);
        acc(A_RD, 1'b1, 8'd255, q);
        get_next(c);
        check("R4 entry 255", c, 24'hAABBCC);
        get_next(c);
        check("R3 R4 entry 0 after wrap", c, 24'h010203);
        acc(A_RD, 1'b0, 8'h00, q);
        check("R4 rd ptr wrap", q, 8'd1);

        // R6: indexed lookup with one clock of latency
        @(negedge clk); pix_mode = 2'd0; pix_data = 24'h0000FF;
        @(negedge clk);
        check("R6 index 255", {pix_red, pix_green, pix_blue}, 24'hAABBCC);
        pix_data = 24'h000005; #1;
        check("R6 no early change", {pix_red, pix_green, pix_blue}, 24'hAABBCC);
        @(negedge clk);
        check("R6 index 5", {pix_red, pix_green, pix_blue}, 24'h112233);

        // R5: pointer writes restart the component phase
        acc(A_WR, 1'b1, 8'd10, q);
        acc(A_DAT, 1'b1, 8'h44, q);
        put_entry(8'd10, 24'h556677);
        acc(A_RD, 1'b1, 8'd10, q);
        acc(A_DAT, 1'b0, 8'h00, q);
        acc(A_RD, 1'b1, 8'd10, q);
        get_next(c);
        check("R5 restart after pointer write", c, 24'h556677);

        // R7: host write visible to pixels one clock after blue
        put_entry(8'd20, 24'h010101);
        @(negedge clk); pix_data = 24'h000014;
        acc(A_WR, 1'b1, 8'd20, q);
        acc(A_DAT, 1'b1, 8'h9A, q);
        acc(A_DAT, 1'b1, 8'hBC, q);
        acc(A_DAT, 1'b1, 8'hDE, q);
        check("R7 old colour at blue edge", {pix_red, pix_green, pix_blue}, 24'h010101);
        @(posedge clk); #1;
        check("R7 new colour next edge", {pix_red, pix_green, pix_blue}, 24'h9ABCDE);

        // R11: unused address
        acc(A_WR, 1'b1, 8'd30, q);
        acc(A_DAT, 1'b1, 8'h10, q);
        acc(A_NONE, 1'b1, 8'h77, q);
        acc(A_NONE, 1'b0, 8'h00, q);
        check("R11 unused reads 0", q, 8'h00);
        acc(A_DAT, 1'b1, 8'h20, q);
        acc(A_DAT, 1'b1, 8'h30, q);
        acc(A_WR, 1'b0, 8'h00, q);
        check("R11 wr ptr untouched", q, 8'd31);
        acc(A_RD, 1'b1, 8'd30, q);
        get_next(c);
        check("R11 phase untouched", c, 24'h102030);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule